// File: doc/BRIEF.md
# Sticky Bridge Diagnostic Register

This block keeps the fault history of a two-output power bridge in one 8-bit word that the serial slave shifts out when the controller asks for diagnostics. The fault classification logic supplies a 2-bit code for each output. It also supplies single-cycle or level event inputs for current limiting, temperature-based current reduction and overtemperature. Every stored indication is active low and sticky. A bit that has dropped to 0 stays at 0 until one of the clear sources returns it to 1, even after the fault input goes away.

Clearing happens in four cases: the disable input is high, the enable input is low, the serial slave pulses a read-clear at the end of a diagnostic read frame, or diagnostic mode is entered. The top bit does not store anything. It shows the enable and disable inputs live. While the supply is under voltage, the two output-code fields read as zero. The held codes are kept underneath and reappear once the supply recovers. The controller cannot write this word.

Top module: `diag_fault_reg`

## Requirements
- R1: After reset the word reads 0xFF (enable high, disable low, no undervoltage). The reset is asynchronous. Its release passes through two flops, so the first stored update happens on the third rising clock edge after `rst_n` rises.
- R2: Bits 1:0 hold the code for output 1: 00 overload short, 01 short to battery, 10 short to ground, 11 no error. A code other than 11 is captured on the clock edge it is presented and is visible in the next cycle. Once a fault code is held, later codes do not replace it until a clear.
- R3: Bits 3:2 hold the code for output 2 with the same capture rules: 00 open load, 01 short to battery, 10 short to ground, 11 no error.
- R4: Bit 4 drops to 0 on a current-limit event, bit 5 on a temperature current-reduction event, and bit 6 on an overtemperature event. Each stays at 0 after the event ends and no clear occurs.
- R5: Bit 7 is 1 only when enable is high and disable is low, and 0 for the other three combinations. It follows the inputs in the same cycle.
- R6: Bits 6:0 return to 1 (codes to 11) on the edge after a cycle with disable high, enable low, the read-clear pulse, or the diagnostic-mode entry pulse.
- R7: While undervoltage is asserted, bits 3:0 read 0000 in the same cycle. When undervoltage is removed, the codes held before and during it reappear unchanged.
- R8: A fault event that arrives in the same cycle as any clear source is stored, and the clear does not discard it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable input level |
| dis_i | input | 1 | Disable input level |
| out1_code_i | input | 2 | Fault classification for output 1 (11 = none) |
| out2_code_i | input | 2 | Fault classification for output 2 (11 = none) |
| curlim_i | input | 1 | Current limitation event |
| curred_i | input | 1 | Temperature-dependent current reduction event |
| ovtemp_i | input | 1 | Overtemperature event |
| uv_i | input | 1 | Supply undervoltage |
| diag_entry_i | input | 1 | Pulse on entry to diagnostic mode |
| rd_clr_i | input | 1 | Pulse from the serial slave ending a diagnostic read |
| diag_o | output | 8 | Register value |

## Verification
The hardest cases to reach are the overlaps. One is a fault code that arrives during undervoltage, which must be stored while it stays hidden. The other is a fault event that coincides with each of the four clear sources. The stimulus sets fault codes first and then raises undervoltage. It presents a new code while undervoltage is held, then drops undervoltage and compares the restored fields. It then pulses a current-limit event and an output code in the same cycle as a read-clear, a mode entry, disable high and enable low in turn. A behavioural model compares the register on every cycle.

// File: rtl/diag_reg_pkg.sv
package diag_reg_pkg;
  localparam int CODE_W    = 2;
  localparam int NUM_OUTS  = 2;
  localparam int NUM_FLAGS = 3;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = '1;
endpackage

// File: rtl/diag_rst_sync.sv
module diag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/diag_clear_decode.sv
module diag_clear_decode (
  input  logic en_i,
  input  logic dis_i,
  input  logic diag_entry_i,
  input  logic rd_clr_i,
  output logic clr_o,
  output logic live_o
);
  always_comb begin
    live_o = en_i & ~dis_i;
    clr_o  = ~live_o | diag_entry_i | rd_clr_i;
  end
endmodule

// File: rtl/diag_code_slot.sv
module diag_code_slot
  import diag_reg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t code_i,
  input  logic  clr_i,
  output code_t code_q_o
);
  code_t code_q, code_d;
  logic  load;

  always_comb begin
    load   = 1'b0;
    code_d = code_q;
    if (code_i != CODE_NONE && (code_q == CODE_NONE || clr_i)) begin
      load   = 1'b1;
      code_d = code_i;
    end else if (clr_i) begin
      load   = 1'b1;
      code_d = CODE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= CODE_NONE;
    else if (load) code_q <= code_d;
  end

  assign code_q_o = code_q;
endmodule

// File: rtl/diag_flag_bit.sv
module diag_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_i,
  output logic flag_q_o
);
  logic flag_q, flag_d, load;

  always_comb begin
    load   = event_i | clr_i;
    flag_d = ~event_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b1;
    else if (load) flag_q <= flag_d;
  end

  assign flag_q_o = flag_q;
endmodule

// File: rtl/diag_fault_reg.sv
module diag_fault_reg
  import diag_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       dis_i,
  input  logic [1:0] out1_code_i,
  input  logic [1:0] out2_code_i,
  input  logic       curlim_i,
  input  logic       curred_i,
  input  logic       ovtemp_i,
  input  logic       uv_i,
  input  logic       diag_entry_i,
  input  logic       rd_clr_i,
  output logic [7:0] diag_o
);
  localparam int CODE_BITS = NUM_OUTS * CODE_W;

  logic                 rst_q_n;
  logic                 clr, live;
  code_t                code_in [NUM_OUTS];
  code_t                code_q  [NUM_OUTS];
  logic [NUM_FLAGS-1:0] flag_evt, flag_q;
  logic [CODE_BITS-1:0] codes_flat;

  diag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  diag_clear_decode u_clr (
    .en_i(en_i), .dis_i(dis_i), .diag_entry_i(diag_entry_i),
    .rd_clr_i(rd_clr_i), .clr_o(clr), .live_o(live)
  );

  assign code_in[0] = out1_code_i;
  assign code_in[1] = out2_code_i;
  assign flag_evt   = {ovtemp_i, curred_i, curlim_i};

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_slot
    diag_code_slot u_slot (
      .clk(clk), .rst_n(rst_q_n), .code_i(code_in[g]),
      .clr_i(clr), .code_q_o(code_q[g])
    );
    assign codes_flat[g*CODE_W +: CODE_W] = code_q[g];
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    diag_flag_bit u_flag (
      .clk(clk), .rst_n(rst_q_n), .event_i(flag_evt[f]),
      .clr_i(clr), .flag_q_o(flag_q[f])
    );
  end

  always_comb begin
    diag_o = {live, flag_q, codes_flat};
    if (uv_i) diag_o[CODE_BITS-1:0] = '0;
  end
endmodule

// File: rtl/diag_fault_reg_chk.sv
module diag_fault_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       dis_i,
  input logic       diag_entry_i,
  input logic       rd_clr_i,
  input logic       curlim_i,
  input logic       curred_i,
  input logic       ovtemp_i,
  input logic       uv_i,
  input logic [1:0] held1,
  input logic [7:0] diag_o
);
  logic any_clr, any_evt;
  assign any_clr = dis_i | ~en_i | diag_entry_i | rd_clr_i;
  assign any_evt = curlim_i | curred_i | ovtemp_i;

  a_r6_clear_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (any_clr && !any_evt) |=> (diag_o[6:4] == 3'b111));

  a_r4_curlim_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_o[4] && !any_clr) |=> !diag_o[4]);

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    curlim_i |=> !diag_o[4]);

  a_r7_uv_hides_codes: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> (diag_o[3:0] == 4'b0000));

  a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (held1 != 2'b11 && !any_clr) |=> (held1 == $past(held1)));
endmodule

bind diag_fault_reg diag_fault_reg_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .en_i(en_i), .dis_i(dis_i),
  .diag_entry_i(diag_entry_i), .rd_clr_i(rd_clr_i), .curlim_i(curlim_i),
  .curred_i(curred_i), .ovtemp_i(ovtemp_i), .uv_i(uv_i),
  .held1(code_q[0]), .diag_o(diag_o)
);

// File: tb/test_diag_fault_reg.sv
module test_diag_fault_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 0, rst_n = 0;
  logic en = 1, dis = 0, curlim = 0, curred = 0, ovtemp = 0, uv = 0;
  logic dentry = 0, rdclr = 0;
  logic [1:0] c1 = 2'b11, c2 = 2'b11;
  logic [7:0] dout;

  int errors = 0, checks = 0, cycles = 0, rcnt = 0;
  string tag = "R1";
  bit done = 0;

  int m_c1 = 3, m_c2 = 3, m_f4 = 1, m_f5 = 1, m_f6 = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_fault_reg i_diag_fault_reg (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dis_i(dis),
    .out1_code_i(c1), .out2_code_i(c2), .curlim_i(curlim),
    .curred_i(curred), .ovtemp_i(ovtemp), .uv_i(uv),
    .diag_entry_i(dentry), .rd_clr_i(rdclr), .diag_o(dout)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    int clr;
    if (!rst_n) begin
      rcnt = 0; m_c1 = 3; m_c2 = 3; m_f4 = 1; m_f5 = 1; m_f6 = 1;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      clr = (dis || !en || dentry || rdclr) ? 1 : 0;
      if (c1 != 3 && (m_c1 == 3 || clr)) m_c1 = c1; else if (clr) m_c1 = 3;
      if (c2 != 3 && (m_c2 == 3 || clr)) m_c2 = c2; else if (clr) m_c2 = 3;
      m_f4 = curlim ? 0 : (clr ? 1 : m_f4);
      m_f5 = curred ? 0 : (clr ? 1 : m_f5);
      m_f6 = ovtemp ? 0 : (clr ? 1 : m_f6);
    end
  end

  function automatic int expect_val();
    int v;
    v = (en && !dis) ? 128 : 0;
    v += m_f6 * 64 + m_f5 * 32 + m_f4 * 16;
    if (!uv) v += m_c2 * 4 + m_c1;
    return v;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (dout !== 8'(expect_val())) begin
        errors++;
        $display("FAIL %s: diag_o=%02h expected %02h at cycle %0d",
                 tag, dout, 8'(expect_val()), cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      done = 1;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    rdclr = 1; step(); rdclr = 0; step();
  endtask

  task automatic point(string t, logic [7:0] want);
    checks++;
    @(negedge clk);
    if (dout !== want) begin
      errors++;
      $display("FAIL %s: diag_o=%02h expected %02h", t, dout, want);
    end
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    tag = "R1"; step(4);
    point("R1 reset value", 8'hFF);

    tag = "R2";
    for (int k = 0; k < 3; k++) begin
      c1 = 2'(k); step(); c1 = 2'b11; step(2);
      c1 = 2'(k + 1 == 3 ? 0 : k + 1); step(); c1 = 2'b11; step();
      point("R2 first code kept", 8'hFC | 8'(k));
      pulse_clear();
    end

    tag = "R3";
    for (int k = 0; k < 3; k++) begin
      c2 = 2'(k); step(); c2 = 2'b11; step();
      c2 = 2'(k == 0 ? 2 : 0); step(); c2 = 2'b11; step();
      point("R3 first code kept", 8'hF3 | 8'(k << 2));
      pulse_clear();
    end

    tag = "R4";
    curlim = 1; step(); curlim = 0; step(3);
    point("R4 curlim sticky", 8'hEF);
    curred = 1; step(2); curred = 0; step();
    ovtemp = 1; step(); ovtemp = 0; step(2);
    point("R4 all flags", 8'h8F);
    pulse_clear();

    tag = "R5";
    for (int k = 0; k < 4; k++) begin
      en = k[0]; dis = k[1]; step(2);
    end
    en = 1; dis = 0; step(2);

    tag = "R6";
    c1 = 2'b01; c2 = 2'b10; curlim = 1; step();
    c1 = 2'b11; c2 = 2'b11; curlim = 0; step();
    dis = 1; step(); point("R6 disable high", 8'h7F); dis = 0; step();
    ovtemp = 1; step(); ovtemp = 0; en = 0; step();
    point("R6 enable low", 8'h7F); en = 1; step();
    curred = 1; step(); curred = 0; dentry = 1; step(); dentry = 0; step();
    point("R6 diag entry", 8'hFF);
    curlim = 1; step(); curlim = 0; rdclr = 1; step(); rdclr = 0; step();
    point("R6 read clear", 8'hFF);

    tag = "R7";
    c1 = 2'b10; step(); c1 = 2'b11; uv = 1; step(2);
    point("R7 uv masks", 8'hF0);
    c2 = 2'b01; step(); c2 = 2'b11; step(2);
    uv = 0; step();
    point("R7 restored", 8'hF6);
    pulse_clear();

    tag = "R8";
    curlim = 1; c1 = 2'b00; rdclr = 1; step();
    curlim = 0; c1 = 2'b11; rdclr = 0; step();
    point("R8 event with read clear", 8'hEC);
    curred = 1; c2 = 2'b10; dentry = 1; step();
    curred = 0; c2 = 2'b11; dentry = 0; step();
    point("R8 event with mode entry", 8'hDB);
    ovtemp = 1; dis = 1; step(); ovtemp = 0; dis = 0; step();
    point("R8 event with disable", 8'hBF);
    c1 = 2'b01; en = 0; step(); c1 = 2'b11; en = 1; step();
    point("R8 event with enable low", 8'hFD);
    pulse_clear();

    tag = "R1";
    rst_n = 0; step(); point("R1 async reset", 8'hFF);
    rst_n = 1; curlim = 1; step(2); curlim = 0; step(2);
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule